// File: doc/BRIEF.md
# USB Full-Speed Packet Transmitter

This block turns one queued USB packet into line signals for an external full-speed transceiver. A one-cycle `send` pulse starts it. It first emits the synchronisation pattern. It then pulls bytes from the head of an endpoint buffer one at a time, each byte under a `byte_take` strobe. The first byte pulled is the packet identifier. The buffer marks the final byte of the packet with `byte_last`. Every byte leaves least significant bit first. For a data packet, a 16-bit CRC over the payload bytes is appended after the last byte. A handshake packet, selected by `send_handshake` at the time of `send`, carries only its identifier and no CRC.

One coder stage inserts stuffed zeros and applies NRZI coding. The same stage drives the transceiver's differential data pins and output enable, and it closes the packet with the end-of-packet signalling. A bit timer sets the bit time to `CLK_PER_BIT` system clocks. The first line symbol appears two clocks after `send`, which keeps the response turnaround short.

The controller has eight states:

| State | Action | Next state |
|---|---|---|
| `ST_IDLE` | Waits for `send` | `ST_SYNC` when `send` arrives |
| `ST_SYNC` | Shifts out the sync byte | `ST_PID` after 8 bits, fetching the first byte |
| `ST_PID` | Sends the identifier | `ST_SE0` for a handshake; `ST_CRC` if the identifier was the last byte; otherwise `ST_DATA`, fetching a byte |
| `ST_DATA` | Sends payload bytes | Another byte after each byte; `ST_CRC` after the last byte |
| `ST_CRC` | Sends 16 CRC bits | `ST_SE0` |
| `ST_SE0` | Holds two bit times of single-ended zero | `ST_JBIT` |
| `ST_JBIT` | Holds one bit time of J | `ST_DONE` |
| `ST_DONE` | Releases the output enable at the next bit boundary | `ST_IDLE` |

Top module: `usb_tx_serializer`

## Requirements
- R1: After reset and between packets, `line_oe` is 0, the line rests at J (`line_dp`=1, `line_dm`=0), `busy` is 0 and `byte_take` is 0.
- R2: The first line symbol is on the pins with `line_oe`=1 two clock cycles after the cycle in which `send` is high. Every symbol then holds for exactly `CLK_PER_BIT` clocks.
- R3: Each packet begins with the bit sequence 0,0,0,0,0,0,0,1 in time order. This is the byte 0x80 sent least significant bit first.
- R4: Bytes are taken one per `byte_take` pulse, starting with the identifier. Each byte is sent LSB first. No byte is taken after the byte marked `byte_last`. A data packet therefore takes exactly as many bytes as the buffer holds up to and including the marked byte.
- R5: A data packet ends with a CRC16 computed over the payload bytes only, excluding the identifier. The CRC uses the reflected polynomial 0xA001 and is preset to 0xFFFF. It is sent inverted and LSB first, so a packet with no payload carries 16 zero bits.
- R6: When `send_handshake` is 1 with `send`, only the identifier byte is taken and sent, with no CRC, whatever the state of `byte_last`.
- R7: After six consecutive one bits, a zero is inserted before the next bit. This counts sync, identifier, payload and CRC bits, and a pending stuffed bit is sent before the end of packet.
- R8: NRZI coding starts from J. A zero bit toggles the line between J (dp=1, dm=0) and K (dp=0, dm=1), and a one bit holds it.
- R9: The packet ends with two bit times of SE0 (dp=0, dm=0), then one bit time of J. `line_oe` then falls at the following bit boundary.
- R10: A `send` pulse while `busy` is 1 is ignored. The packet in flight goes on unchanged and no extra byte is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| send | input | 1 | One-cycle command to start a packet |
| send_handshake | input | 1 | Sampled with `send`: 1 selects a handshake packet |
| byte_data | input | 8 | Byte at the head of the endpoint buffer |
| byte_last | input | 1 | Marks the head byte as the final byte of the packet |
| byte_take | output | 1 | Consumes the head byte of the buffer |
| line_dp | output | 1 | Transceiver D+ drive value |
| line_dm | output | 1 | Transceiver D- drive value |
| line_oe | output | 1 | Transceiver output enable |
| busy | output | 1 | A packet is in progress |

## Verification
The bench tries the block with several byte patterns:
- Handshake identifiers with no trailing bytes, which separate the CRC bypass from the data path.
- A data packet with no payload, which isolates the preset-and-invert rule of the CRC.
- Short mixed payloads, which test byte order and bit order.
- Long runs of 0xFF, which force repeated stuffed bits, including stuffed bits inside the CRC and just before the end of packet.

Each captured line stream is compared symbol by symbol with a model that encodes the packet from the requirements. A handshake with the buffer's last mark withheld shows whether the handshake decision ignores that mark. A `send` pulse in the middle of a packet shows whether a running packet can be restarted.

// File: rtl/usbtx_pkg.sv
package usbtx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_PID,
        ST_DATA,
        ST_CRC,
        ST_SE0,
        ST_JBIT,
        ST_DONE
    } tx_state_t;

    // Symbol request from the controller to the line coder
    typedef enum logic [1:0] {
        SYM_BIT,
        SYM_SE0,
        SYM_J,
        SYM_OFF
    } sym_t;

    localparam logic [7:0]  SYNC_PATTERN = 8'h80;
    localparam int          STUFF_RUN    = 6;
    localparam int          CRC_W        = 16;
    localparam logic [15:0] CRC_POLY_REV = 16'hA001;

endpackage

// File: rtl/usbtx_bit_timer.sv
module usbtx_bit_timer #(
    parameter int CLK_PER_BIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int          CW   = (CLK_PER_BIT > 1) ? $clog2(CLK_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_BIT - 1);

    logic [CW-1:0] phase;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase <= '0;
        end else if (phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign tick = run && (phase == '0);

    generate
        if (CLK_PER_BIT > 1) begin : g_spacing
            AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R2
        end
    endgenerate

endmodule

// File: rtl/usbtx_crc16.sv
module usbtx_crc16 #(
    parameter int              W    = 16,
    parameter logic [W-1:0]    POLY = 16'hA001
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] crc_q,
    output logic [W-1:0] crc_next
);
    logic fb;

    assign fb       = crc_q[0] ^ din;
    assign crc_next = shift ? ((crc_q >> 1) ^ (fb ? POLY : '0)) : crc_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            crc_q <= '1;
        end else begin
            crc_q <= crc_next;
        end
    end

    AST_CRC_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (crc_q == '1)); // R5

endmodule

// File: rtl/usbtx_coder.sv
module usbtx_coder
    import usbtx_pkg::*;
#(
    parameter int RUN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  sym_t sym,
    input  logic din,
    output logic take,
    output logic line_dp,
    output logic line_dm,
    output logic line_oe
);
    localparam int OW = $clog2(RUN + 1);

    logic          lvl;
    logic          se0;
    logic          oe;
    logic [OW-1:0] ones;
    logic          stuff_due;

    assign stuff_due = (ones == OW'(RUN));
    assign take      = tick && !stuff_due;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl  <= 1'b1;
            se0  <= 1'b0;
            oe   <= 1'b0;
            ones <= '0;
        end else if (tick) begin
            if (stuff_due) begin
                lvl  <= ~lvl;
                se0  <= 1'b0;
                oe   <= 1'b1;
                ones <= '0;
            end else begin
                unique case (sym)
                    SYM_BIT: begin
                        oe  <= 1'b1;
                        se0 <= 1'b0;
                        if (din) begin
                            ones <= ones + 1'b1;
                        end else begin
                            lvl  <= ~lvl;
                            ones <= '0;
                        end
                    end
                    SYM_SE0: begin
                        oe   <= 1'b1;
                        se0  <= 1'b1;
                        ones <= '0;
                    end
                    SYM_J: begin
                        oe   <= 1'b1;
                        se0  <= 1'b0;
                        lvl  <= 1'b1;
                        ones <= '0;
                    end
                    SYM_OFF: begin
                        oe   <= 1'b0;
                        se0  <= 1'b0;
                        lvl  <= 1'b1;
                        ones <= '0;
                    end
                endcase
            end
        end
    end

    assign line_dp = lvl & ~se0;
    assign line_dm = ~lvl & ~se0;
    assign line_oe = oe;

    AST_NRZI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (take && sym == SYM_BIT && !din && !se0) |=> (line_dp != $past(line_dp))); // R8

    AST_NRZI_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (take && sym == SYM_BIT && din && !se0 && oe) |=> $stable(line_dp)); // R8

    AST_STUFF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && stuff_due && !se0) |=> (line_dp != $past(line_dp))); // R7

endmodule

// File: rtl/usb_tx_serializer.sv
module usb_tx_serializer
    import usbtx_pkg::*;
#(
    parameter int CLK_PER_BIT = 4,
    parameter int BYTE_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              send,
    input  logic              send_handshake,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              byte_last,
    output logic              byte_take,
    output logic              line_dp,
    output logic              line_dm,
    output logic              line_oe,
    output logic              busy
);
    localparam int            SH_W     = CRC_W;
    localparam int            CNT_W    = $clog2(SH_W);
    localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] CRC_END  = CNT_W'(CRC_W - 1);
    localparam logic [CNT_W-1:0] SE0_END  = CNT_W'(1);

    tx_state_t        state, nxt_state;
    logic [SH_W-1:0]  sh, nxt_sh;
    logic [CNT_W-1:0] cnt, nxt_cnt;
    logic             hs, nxt_hs;
    logic             last_seen, nxt_last;

    logic             tick;
    logic             take;
    sym_t             sym;
    logic             din;
    logic             crc_shift;
    logic             crc_clear;
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_next;

    usbtx_bit_timer #(
        .CLK_PER_BIT(CLK_PER_BIT)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state != ST_IDLE),
        .tick (tick)
    );

    usbtx_crc16 #(
        .W   (CRC_W),
        .POLY(CRC_POLY_REV)
    ) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (crc_clear),
        .shift   (crc_shift),
        .din     (din),
        .crc_q   (crc_q),
        .crc_next(crc_next)
    );

    usbtx_coder #(
        .RUN(STUFF_RUN)
    ) u_coder (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .sym    (sym),
        .din    (din),
        .take   (take),
        .line_dp(line_dp),
        .line_dm(line_dm),
        .line_oe(line_oe)
    );

    // Next state and datapath loads
    always_comb begin
        nxt_state = state;
        nxt_sh    = sh;
        nxt_cnt   = cnt;
        nxt_hs    = hs;
        nxt_last  = last_seen;
        unique case (state)
            ST_IDLE: begin
                if (send) begin
                    nxt_state = ST_SYNC;
                    nxt_sh    = {{(SH_W-8){1'b0}}, SYNC_PATTERN};
                    nxt_cnt   = '0;
                    nxt_hs    = send_handshake;
                end
            end
            ST_SYNC: begin
                if (take) begin
                    if (cnt == BYTE_END) begin
                        nxt_state = ST_PID;
                        nxt_sh    = {{(SH_W-BYTE_W){1'b0}}, byte_data};
                        nxt_cnt   = '0;
                        nxt_last  = byte_last;
                    end else begin
                        nxt_sh  = sh >> 1;
                        nxt_cnt = cnt + 1'b1;
                    end
                end
            end
            ST_PID, ST_DATA: begin
                if (take) begin
                    if (cnt == BYTE_END) begin
                        nxt_cnt = '0;
                        if (state == ST_PID && hs) begin
                            nxt_state = ST_SE0;
                        end else if (last_seen) begin
                            nxt_state = ST_CRC;
                            nxt_sh    = ~crc_next;
                        end else begin
                            nxt_state = ST_DATA;
                            nxt_sh    = {{(SH_W-BYTE_W){1'b0}}, byte_data};
                            nxt_last  = byte_last;
                        end
                    end else begin
                        nxt_sh  = sh >> 1;
                        nxt_cnt = cnt + 1'b1;
                    end
                end
            end
            ST_CRC: begin
                if (take) begin
                    if (cnt == CRC_END) begin
                        nxt_state = ST_SE0;
                        nxt_cnt   = '0;
                    end else begin
                        nxt_sh  = sh >> 1;
                        nxt_cnt = cnt + 1'b1;
                    end
                end
            end
            ST_SE0: begin
                if (take) begin
                    if (cnt == SE0_END) begin
                        nxt_state = ST_JBIT;
                        nxt_cnt   = '0;
                    end else begin
                        nxt_cnt = cnt + 1'b1;
                    end
                end
            end
            ST_JBIT: begin
                if (take) nxt_state = ST_DONE;
            end
            ST_DONE: begin
                if (take) nxt_state = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            sh        <= '0;
            cnt       <= '0;
            hs        <= 1'b0;
            last_seen <= 1'b0;
        end else begin
            state     <= nxt_state;
            sh        <= nxt_sh;
            cnt       <= nxt_cnt;
            hs        <= nxt_hs;
            last_seen <= nxt_last;
        end
    end

    // Outputs of the controller
    always_comb begin
        din       = sh[0];
        sym       = SYM_OFF;
        byte_take = 1'b0;
        unique case (state)
            ST_IDLE:  sym = SYM_OFF;
            ST_SYNC: begin
                sym       = SYM_BIT;
                byte_take = take && (cnt == BYTE_END);
            end
            ST_PID: begin
                sym       = SYM_BIT;
                byte_take = take && (cnt == BYTE_END) && !hs && !last_seen;
            end
            ST_DATA: begin
                sym       = SYM_BIT;
                byte_take = take && (cnt == BYTE_END) && !last_seen;
            end
            ST_CRC:   sym = SYM_BIT;
            ST_SE0:   sym = SYM_SE0;
            ST_JBIT:  sym = SYM_J;
            ST_DONE:  sym = SYM_OFF;
        endcase
    end

    assign crc_clear = (state == ST_IDLE);
    assign crc_shift = take && (state == ST_DATA);
    assign busy      = (state != ST_IDLE);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!line_oe && line_dp && !line_dm)); // R1

    AST_TAKE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_take |-> (state == ST_SYNC || state == ST_PID || state == ST_DATA)); // R4

    AST_HS_NO_CRC: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && state != ST_IDLE) |-> (state != ST_DATA && state != ST_CRC)); // R6

    AST_RELEASE_AFTER_J: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_oe) |-> ($past(line_dp) && !$past(line_dm))); // R9

    AST_SEND_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && send) |=> (state != ST_SYNC || $past(state) == ST_SYNC)); // R10

endmodule

// File: tb/sim_usb_tx_serializer.sv
module sim_usb_tx_serializer;
    localparam int CLK_PERIOD = 10;
    localparam int CPB        = 4;
    localparam int MAXSYM     = 300;
    localparam int NVEC       = 6;

    // {handshake, byte count, expected takes, byte0..byte3}
    localparam logic [40:0] VEC [0:NVEC-1] = '{
        {1'b1, 4'd1, 4'd1, 32'hD2000000},
        {1'b1, 4'd1, 4'd1, 32'h5A000000},
        {1'b0, 4'd4, 4'd4, 32'hC3010203},
        {1'b0, 4'd4, 4'd4, 32'h4BFFFFFF},
        {1'b0, 4'd1, 4'd1, 32'hC3000000},
        {1'b0, 4'd2, 4'd2, 32'hC3AA0000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic send = 1'b0;
    logic send_handshake = 1'b0;
    logic [7:0] byte_data;
    logic byte_last;
    logic byte_take;
    logic line_dp, line_dm, line_oe, busy;

    logic [7:0] bufm [0:15];
    int nbytes = 1;
    int takes = 0;
    int base = 0;
    int checks = 0;
    int fails = 0;

    logic [1:0] exp_sym [0:MAXSYM-1];
    logic [1:0] got_sym [0:MAXSYM-1];
    int exp_n, got_n;
    logic m_lvl;
    int m_ones;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (byte_take) takes <= takes + 1;

    always_comb begin
        byte_data = bufm[4'(takes - base)];
        byte_last = ((takes - base) == (nbytes - 1));
    end

    usb_tx_serializer #(.CLK_PER_BIT(CPB)) u0 (
        .clk(clk), .rst_n(rst_n), .send(send), .send_handshake(send_handshake),
        .byte_data(byte_data), .byte_last(byte_last), .byte_take(byte_take),
        .line_dp(line_dp), .line_dm(line_dm), .line_oe(line_oe), .busy(busy)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push_sym(input logic [1:0] s);
        if (exp_n < MAXSYM) exp_sym[exp_n] = s;
        exp_n++;
    endtask

    task automatic push_bit(input logic b);
        if (m_ones == 6) begin
            m_lvl = ~m_lvl; m_ones = 0; push_sym({m_lvl, ~m_lvl});
        end
        if (b) m_ones++;
        else begin m_lvl = ~m_lvl; m_ones = 0; end
        push_sym({m_lvl, ~m_lvl});
    endtask

    task automatic push_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) push_bit(v[i]);
    endtask

    // Encoder model built from the requirements
    task automatic build_model(input logic hs, input int n);
        logic [15:0] crc;
        logic fb;
        exp_n = 0; m_lvl = 1'b1; m_ones = 0;
        push_byte(8'h80);
        push_byte(bufm[0]);
        if (!hs) begin
            crc = 16'hFFFF;
            for (int k = 1; k < n; k++) begin
                for (int i = 0; i < 8; i++) begin
                    push_bit(bufm[k][i]);
                    fb = crc[0] ^ bufm[k][i];
                    crc = crc >> 1;
                    if (fb) crc = crc ^ 16'hA001;
                end
            end
            crc = ~crc;
            for (int i = 0; i < 16; i++) push_bit(crc[i]);
        end
        if (m_ones == 6) begin m_lvl = ~m_lvl; push_sym({m_lvl, ~m_lvl}); end
        push_sym(2'b00); push_sym(2'b00); push_sym(2'b10);
    endtask

    task automatic run_pkt(input logic hs, input int n, input int exp_takes,
                           input logic poke, input string tag);
        int hold_bad;
        int mism;
        logic [1:0] s0;
        nbytes = n;
        base = takes;
        build_model(hs, n);
        @(negedge clk);
        send = 1'b1; send_handshake = hs;
        @(negedge clk);
        send = 1'b0;
        check(line_oe == 1'b0, "R2 no symbol one cycle after send", int'(line_oe), 0);
        @(negedge clk);
        check(line_oe == 1'b1, "R2 first symbol two cycles after send", int'(line_oe), 1);
        got_n = 0; hold_bad = 0;
        while (line_oe && got_n < MAXSYM) begin
            s0 = {line_dp, line_dm};
            got_sym[got_n] = s0;
            got_n++;
            for (int c = 0; c < CPB; c++) begin
                @(negedge clk);
                send = (poke && got_n == 20 && c == 0);
                if (c < CPB - 1 && {line_dp, line_dm} != s0) hold_bad++;
            end
        end
        send = 1'b0;
        check(hold_bad == 0, "R2 symbol held for a full bit time", hold_bad, 0);
        check(got_n == exp_n, {tag, " R7 R9 symbol count"}, got_n, exp_n);
        mism = -1;
        for (int i = 0; i < got_n && i < exp_n; i++)
            if (mism < 0 && got_sym[i] != exp_sym[i]) mism = i;
        check(mism < 0, {tag, " R3 R8 stream first mismatch index"}, mism, -1);
        if (mism >= 0)
            $display("  symbol %0d: actual=%b expected=%b", mism, got_sym[mism], exp_sym[mism]);
        if (got_n >= 3)
            check(got_sym[got_n-3] == 2'b00 && got_sym[got_n-2] == 2'b00 && got_sym[got_n-1] == 2'b10,
                  "R9 end of packet SE0 SE0 J", int'({got_sym[got_n-3], got_sym[got_n-2], got_sym[got_n-1]}), 6'b000010);
        check((takes - base) == exp_takes, {tag, " R4 bytes taken"}, takes - base, exp_takes);
        check(!busy && line_dp && !line_dm && !line_oe, "R1 idle after packet",
              int'({busy, line_oe, line_dp, line_dm}), 4'b0010);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) bufm[i] = 8'h00;
        repeat (3) @(negedge clk);
        check(!line_oe && line_dp && !line_dm && !busy && !byte_take, "R1 reset state",
              int'({line_oe, line_dp, line_dm, busy, byte_take}), 5'b01000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!line_oe && !busy, "R1 idle after reset", int'({line_oe, busy}), 0);

        // Table-driven packets
        for (int v = 0; v < NVEC; v++) begin
            for (int i = 0; i < 4; i++) bufm[i] = VEC[v][31 - 8*i -: 8];
            run_pkt(VEC[v][40], int'(VEC[v][39:36]), int'(VEC[v][35:32]), 1'b0,
                    VEC[v][40] ? "R6" : "R5");
        end

        // Handshake with the last mark withheld: only the identifier goes out
        bufm[0] = 8'hD2; bufm[1] = 8'h11; bufm[2] = 8'h22;
        run_pkt(1'b1, 3, 1, 1'b0, "R6 no last mark");

        // Long run of ones: stuffing throughout
        bufm[0] = 8'hC3;
        for (int i = 1; i < 8; i++) bufm[i] = 8'hFF;
        run_pkt(1'b0, 8, 8, 1'b0, "R7 all ones");

        // Payload ending in ones, checked against a pending stuff before EOP
        bufm[0] = 8'h4B; bufm[1] = 8'h7E; bufm[2] = 8'hFC;
        run_pkt(1'b0, 3, 3, 1'b0, "R7 tail ones");

        // Send pulse during a packet is ignored
        bufm[0] = 8'hC3; bufm[1] = 8'h12; bufm[2] = 8'h34; bufm[3] = 8'h56;
        run_pkt(1'b0, 4, 4, 1'b1, "R10 send while busy");
        repeat (CPB * 4) @(negedge clk);
        check(!busy && !line_oe, "R10 no restart after ignored send", int'({busy, line_oe}), 0);

        // Back-to-back packets
        bufm[0] = 8'h5A;
        run_pkt(1'b1, 1, 1, 1'b0, "R6 back to back");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule